// File: doc/BRIEF.md
# Epoch-Ordered Speculative Retire Controller

This block holds a small table of speculative continuations and retires them one at a time in strict epoch order. A continuation enters through a valid/ready stream and carries five fields: an instruction pointer, a register-set id, an 8-bit epoch, a retry instruction pointer and the id of the address buffer that tracks its speculative reads. When the thread behind a continuation finishes, the surrounding scheduler pulses `done_pulse` with that epoch. Finished entries wait in the table until their epoch is the one expected next.

Once the entry with the expected epoch has finished, the controller reads the conflict bit of that entry's address buffer. The coherence logic that sets these bits lies outside the block and arrives as the vector `viol_vec`. If the bit is clear, the controller emits a one-cycle commit pulse, frees the slot and advances the expected epoch. If the bit is set, it rewrites the entry's instruction pointer with the retry pointer and presents the continuation on the retry stream to the non-speculative ready queue. The entry keeps its epoch and its slot, and waits to be finished again. Every decision also pulses a clear strobe naming the address buffer of the retired thread.

Back-pressure rules: on the insert stream, `ins_ready` depends only on the table state, and an entry is taken on any edge where `ins_valid` and `ins_ready` are both high. On the retry stream, the payload stays stable while `retry_valid` is high and `retry_ready` is low. A violating decision that would load a new retry waits until the stream is empty or being drained in that cycle.

Top module: `spec_commit_ctrl`

## Requirements
- R1: `ins_ready` is high exactly when at least one of the NSLOT table slots is free. When all slots are full, `ins_valid` is ignored and no entry is overwritten.
- R2: A decision is made only for a finished entry whose epoch equals `next_epoch`. Finished entries with later epochs produce no commit and no retry until every earlier epoch has committed.
- R3: If the head's address-buffer bit `viol_vec[abi]` is 0 in the decision cycle, `commit_pulse` is high for exactly one cycle. In that cycle, `commit_epoch`, `commit_ip`, `commit_rs` and `commit_abi` show the entry, and `next_epoch` has advanced by one.
- R4: If that bit is 1, the retry stream presents the entry with `retry_ip` equal to its retry pointer and with its own epoch, register set and buffer id. `next_epoch` is unchanged.
- R5: A retried entry stays in the table with its instruction pointer replaced by the retry pointer. After a new `done_pulse` for its epoch, it is decided again, and a later commit reports the retry pointer on `commit_ip`.
- R6: While `retry_valid` is high and `retry_ready` is low, the retry payload is held. A further violating decision waits until the transfer is accepted, and can fire in the same cycle as that acceptance.
- R7: Every commit or retry decision raises `clr_pulse` for one cycle, with `clr_abi` naming the head's address buffer.
- R8: The expected epoch counts modulo 256, so epoch 0 follows epoch 255 with no gap.
- R9: After reset, `next_epoch` is 0, the table is empty (`ins_ready` high), and `commit_pulse`, `retry_valid` and `clr_pulse` are low.
- R10: A `done_pulse` sampled at one clock edge marks the entry. The resulting commit or retry appears on the outputs after the following edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Insert stream valid |
| ins_ready | output | 1 | A free slot exists |
| ins_ip | input | IPW | Instruction pointer of the new continuation |
| ins_rs | input | RSW | Register-set id |
| ins_epoch | input | EW | Epoch number |
| ins_retry_ip | input | IPW | Retry instruction pointer |
| ins_abi | input | log2(NBUF) | Address-buffer id |
| done_pulse | input | 1 | The thread with epoch `done_epoch` has finished |
| done_epoch | input | EW | Epoch of the finished thread |
| viol_vec | input | NBUF | Conflict bit per address buffer |
| commit_pulse | output | 1 | One-cycle commit strobe |
| commit_epoch | output | EW | Epoch of the committed entry |
| commit_ip | output | IPW | Instruction pointer of the committed entry |
| commit_rs | output | RSW | Register set of the committed entry |
| commit_abi | output | log2(NBUF) | Address buffer of the committed entry |
| retry_valid | output | 1 | Retry stream valid |
| retry_ready | input | 1 | Non-speculative queue accepts |
| retry_ip | output | IPW | Retry pointer, now the entry's instruction pointer |
| retry_rs | output | RSW | Register set of the retried entry |
| retry_epoch | output | EW | Epoch of the retried entry |
| retry_abi | output | log2(NBUF) | Address buffer of the retried entry |
| clr_pulse | output | 1 | Clear strobe for an address buffer |
| clr_abi | output | log2(NBUF) | Buffer to clear |
| next_epoch | output | EW | Epoch expected to retire next |

## Verification
The bench builds the block with four slots, four address buffers and the full 8-bit epoch. Every batch therefore fills the table completely and tests the ignored insert at full occupancy. Because a run retires more than 256 epochs, the counter wraps past 255 during random traffic. Randomly placed conflict bits, combined with random back-pressure on the retry stream, reach both a retry followed by a re-commit and a violating decision that is held behind a stalled retry transfer.

// File: rtl/spec_commit_pkg.sv
package spec_commit_pkg;
  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,
    DEC_COMMIT = 2'd1,
    DEC_RETRY  = 2'd2
  } dec_e;
endpackage

// File: rtl/spec_slot_table.sv
module spec_slot_table #(
  parameter int NSLOT = 4,
  parameter int IPW   = 16,
  parameter int RSW   = 4,
  parameter int EW    = 8,
  parameter int ABW   = 2,
  parameter int SW    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SW-1:0]               wr_idx,
  input  logic [IPW-1:0]              wr_ip,
  input  logic [RSW-1:0]              wr_rs,
  input  logic [EW-1:0]               wr_ep,
  input  logic [IPW-1:0]              wr_rip,
  input  logic [ABW-1:0]              wr_abi,
  input  logic                        done_pulse,
  input  logic [EW-1:0]               done_epoch,
  input  logic                        free_en,
  input  logic [SW-1:0]               free_idx,
  input  logic                        redo_en,
  input  logic [SW-1:0]               redo_idx,
  output logic [NSLOT-1:0]            vld,
  output logic [NSLOT-1:0]            fin,
  output logic [NSLOT-1:0][IPW-1:0]   ip,
  output logic [NSLOT-1:0][RSW-1:0]   rs,
  output logic [NSLOT-1:0][EW-1:0]    ep,
  output logic [NSLOT-1:0][IPW-1:0]   rip,
  output logic [NSLOT-1:0][ABW-1:0]   abi
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic sel_wr, sel_free, sel_redo, sel_done;
    assign sel_wr   = wr_en   && (wr_idx   == SW'(g));
    assign sel_free = free_en && (free_idx == SW'(g));
    assign sel_redo = redo_en && (redo_idx == SW'(g));
    assign sel_done = done_pulse && vld[g] && (ep[g] == done_epoch);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[g] <= 1'b0;
        fin[g] <= 1'b0;
        ip[g]  <= '0;
        rs[g]  <= '0;
        ep[g]  <= '0;
        rip[g] <= '0;
        abi[g] <= '0;
      end else if (sel_wr) begin
        vld[g] <= 1'b1;
        fin[g] <= 1'b0;
        ip[g]  <= wr_ip;
        rs[g]  <= wr_rs;
        ep[g]  <= wr_ep;
        rip[g] <= wr_rip;
        abi[g] <= wr_abi;
      end else begin
        if (sel_free) begin
          vld[g] <= 1'b0;
          fin[g] <= 1'b0;
        end else if (sel_redo) begin
          ip[g]  <= rip[g];
          fin[g] <= 1'b0;
        end else if (sel_done) begin
          fin[g] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spec_pick.sv
module spec_pick #(
  parameter int NSLOT = 4,
  parameter int EW    = 8,
  parameter int SW    = 2
) (
  input  logic [NSLOT-1:0]         vld,
  input  logic [NSLOT-1:0]         fin,
  input  logic [NSLOT-1:0][EW-1:0] ep,
  input  logic [EW-1:0]            want,
  output logic                     free_any,
  output logic [SW-1:0]            free_idx,
  output logic                     hit,
  output logic [SW-1:0]            hit_idx
);
  logic [NSLOT-1:0] match;

  for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
    assign match[g] = vld[g] && fin[g] && (ep[g] == want);
  end

  // lowest index wins in both searches
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    hit      = 1'b0;
    hit_idx  = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_any = 1'b1;
        free_idx = SW'(i);
      end
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = SW'(i);
      end
    end
  end
endmodule

// File: rtl/spec_commit_ctrl.sv
module spec_commit_ctrl
  import spec_commit_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int NBUF   = 4,
  parameter int IPW    = 16,
  parameter int RSW    = 4,
  parameter int EW     = 8,
  parameter int EPOCH0 = 0,
  localparam int ABW   = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [IPW-1:0]   ins_ip,
  input  logic [RSW-1:0]   ins_rs,
  input  logic [EW-1:0]    ins_epoch,
  input  logic [IPW-1:0]   ins_retry_ip,
  input  logic [ABW-1:0]   ins_abi,
  input  logic             done_pulse,
  input  logic [EW-1:0]    done_epoch,
  input  logic [NBUF-1:0]  viol_vec,
  output logic             commit_pulse,
  output logic [EW-1:0]    commit_epoch,
  output logic [IPW-1:0]   commit_ip,
  output logic [RSW-1:0]   commit_rs,
  output logic [ABW-1:0]   commit_abi,
  output logic             retry_valid,
  input  logic             retry_ready,
  output logic [IPW-1:0]   retry_ip,
  output logic [RSW-1:0]   retry_rs,
  output logic [EW-1:0]    retry_epoch,
  output logic [ABW-1:0]   retry_abi,
  output logic             clr_pulse,
  output logic [ABW-1:0]   clr_abi,
  output logic [EW-1:0]    next_epoch
);
  logic [NSLOT-1:0]           t_vld, t_fin;
  logic [NSLOT-1:0][IPW-1:0]  t_ip, t_rip;
  logic [NSLOT-1:0][RSW-1:0]  t_rs;
  logic [NSLOT-1:0][EW-1:0]   t_ep;
  logic [NSLOT-1:0][ABW-1:0]  t_abi;

  logic           free_any, hit;
  logic [SW-1:0]  free_idx, hit_idx;
  dec_e           dec;
  logic           head_conflict, retry_slot_open;

  spec_pick #(.NSLOT(NSLOT), .EW(EW), .SW(SW)) u_pick (
    .vld(t_vld), .fin(t_fin), .ep(t_ep), .want(next_epoch),
    .free_any(free_any), .free_idx(free_idx),
    .hit(hit), .hit_idx(hit_idx)
  );

  assign ins_ready = free_any;

  spec_slot_table #(
    .NSLOT(NSLOT), .IPW(IPW), .RSW(RSW), .EW(EW), .ABW(ABW), .SW(SW)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ins_valid && free_any), .wr_idx(free_idx),
    .wr_ip(ins_ip), .wr_rs(ins_rs), .wr_ep(ins_epoch),
    .wr_rip(ins_retry_ip), .wr_abi(ins_abi),
    .done_pulse(done_pulse), .done_epoch(done_epoch),
    .free_en(dec == DEC_COMMIT), .free_idx(hit_idx),
    .redo_en(dec == DEC_RETRY), .redo_idx(hit_idx),
    .vld(t_vld), .fin(t_fin), .ip(t_ip), .rs(t_rs), .ep(t_ep),
    .rip(t_rip), .abi(t_abi)
  );

  assign head_conflict   = viol_vec[t_abi[hit_idx]];
  assign retry_slot_open = !retry_valid || retry_ready;

  always_comb begin
    dec = DEC_IDLE;
    if (hit) begin
      if (!head_conflict)       dec = DEC_COMMIT;
      else if (retry_slot_open) dec = DEC_RETRY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_epoch   <= EW'(EPOCH0);
      commit_pulse <= 1'b0;
      commit_epoch <= '0;
      commit_ip    <= '0;
      commit_rs    <= '0;
      commit_abi   <= '0;
      retry_valid  <= 1'b0;
      retry_ip     <= '0;
      retry_rs     <= '0;
      retry_epoch  <= '0;
      retry_abi    <= '0;
      clr_pulse    <= 1'b0;
      clr_abi      <= '0;
    end else begin
      commit_pulse <= (dec == DEC_COMMIT);
      clr_pulse    <= (dec != DEC_IDLE);
      if (dec != DEC_IDLE) clr_abi <= t_abi[hit_idx];
      if (dec == DEC_COMMIT) begin
        commit_epoch <= t_ep[hit_idx];
        commit_ip    <= t_ip[hit_idx];
        commit_rs    <= t_rs[hit_idx];
        commit_abi   <= t_abi[hit_idx];
        next_epoch   <= next_epoch + 1'b1;
      end
      if (retry_valid && retry_ready) retry_valid <= 1'b0;
      if (dec == DEC_RETRY) begin
        retry_valid <= 1'b1;
        retry_ip    <= t_rip[hit_idx];
        retry_rs    <= t_rs[hit_idx];
        retry_epoch <= t_ep[hit_idx];
        retry_abi   <= t_abi[hit_idx];
      end
    end
  end
endmodule

// File: rtl/spec_commit_chk.sv
module spec_commit_chk #(
  parameter int NBUF = 4,
  parameter int IPW  = 16,
  parameter int EW   = 8,
  localparam int ABW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NBUF-1:0] viol_vec,
  input logic            commit_pulse,
  input logic [EW-1:0]   commit_epoch,
  input logic [ABW-1:0]  commit_abi,
  input logic            retry_valid,
  input logic            retry_ready,
  input logic [IPW-1:0]  retry_ip,
  input logic [EW-1:0]   retry_epoch,
  input logic            clr_pulse,
  input logic [EW-1:0]   next_epoch
);
  logic            seen_q;
  logic [EW-1:0]   last_q;
  logic [NBUF-1:0] viol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= '0;
      viol_q <= '0;
    end else begin
      viol_q <= viol_vec;
      if (commit_pulse) begin
        seen_q <= 1'b1;
        last_q <= commit_epoch;
      end
    end
  end

  // R2
  epoch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && seen_q) |-> (commit_epoch == EW'(last_q + 1'b1)));

  // R3
  clean_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (viol_q[commit_abi] == 1'b0));

  // R8
  epoch_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (next_epoch == EW'(commit_epoch + 1'b1)));

  // R4
  retry_hold_epoch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !commit_pulse) |-> (next_epoch == $past(next_epoch)));

  // R6
  retry_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_valid && !retry_ready) |=> (retry_valid && $stable(retry_ip) && $stable(retry_epoch)));

  // R7
  clr_with_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> clr_pulse);
endmodule

bind spec_commit_ctrl spec_commit_chk #(.NBUF(NBUF), .IPW(IPW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .viol_vec(viol_vec),
  .commit_pulse(commit_pulse), .commit_epoch(commit_epoch), .commit_abi(commit_abi),
  .retry_valid(retry_valid), .retry_ready(retry_ready), .retry_ip(retry_ip),
  .retry_epoch(retry_epoch), .clr_pulse(clr_pulse), .next_epoch(next_epoch)
);

// File: tb/sim_spec_commit_ctrl.sv
module sim_spec_commit_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [15:0] ins_ip = '0, ins_retry_ip = '0;
  logic [3:0]  ins_rs = '0;
  logic [7:0]  ins_epoch = '0;
  logic [1:0]  ins_abi = '0;
  logic        done_pulse = 1'b0;
  logic [7:0]  done_epoch = '0;
  logic [3:0]  viol_vec;
  logic        commit_pulse;
  logic [7:0]  commit_epoch;
  logic [15:0] commit_ip;
  logic [3:0]  commit_rs;
  logic [1:0]  commit_abi;
  logic        retry_valid;
  logic        retry_ready = 1'b0;
  logic [15:0] retry_ip;
  logic [3:0]  retry_rs;
  logic [7:0]  retry_epoch;
  logic [1:0]  retry_abi;
  logic        clr_pulse;
  logic [1:0]  clr_abi;
  logic [7:0]  next_epoch;

  spec_commit_ctrl #(.NSLOT(4), .NBUF(4), .IPW(16), .RSW(4), .EW(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_ip(ins_ip), .ins_rs(ins_rs),
    .ins_epoch(ins_epoch), .ins_retry_ip(ins_retry_ip), .ins_abi(ins_abi),
    .done_pulse(done_pulse), .done_epoch(done_epoch), .viol_vec(viol_vec),
    .commit_pulse(commit_pulse), .commit_epoch(commit_epoch), .commit_ip(commit_ip),
    .commit_rs(commit_rs), .commit_abi(commit_abi),
    .retry_valid(retry_valid), .retry_ready(retry_ready), .retry_ip(retry_ip),
    .retry_rs(retry_rs), .retry_epoch(retry_epoch), .retry_abi(retry_abi),
    .clr_pulse(clr_pulse), .clr_abi(clr_abi), .next_epoch(next_epoch)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [15:0] m_ip [256];
  logic [15:0] m_rip[256];
  logic [3:0]  m_rs [256];
  logic [1:0]  m_abi[256];
  bit          m_retried[256];
  bit          m_pend[256];
  logic [3:0]  m_viol = '0;
  logic [7:0]  m_exp = '0;
  int          n_commit = 0, n_retry = 0;
  bit          rr_mode = 0, rr_force = 0;

  assign viol_vec = m_viol;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // monitor: decisions are identified by the clear strobe
  logic [7:0] mon_e;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (clr_pulse) begin
        mon_e = m_exp;
        chk(clr_abi == m_abi[mon_e], "R7", "clr_abi", clr_abi, m_abi[mon_e]);
        if (m_viol[m_abi[mon_e]]) begin
          chk(!commit_pulse && retry_valid, "R4", "retry instead of commit", retry_valid, 1);
          chk(retry_epoch == mon_e, "R4", "retry_epoch", retry_epoch, mon_e);
          chk(retry_ip == m_rip[mon_e], "R4", "retry_ip", retry_ip, m_rip[mon_e]);
          chk(retry_rs == m_rs[mon_e], "R4", "retry_rs", retry_rs, m_rs[mon_e]);
          chk(next_epoch == m_exp, "R4", "next_epoch held", next_epoch, m_exp);
          m_viol[m_abi[mon_e]] = 1'b0;
          m_retried[mon_e] = 1;
          m_pend[mon_e] = 1;
          n_retry++;
        end else begin
          chk(commit_pulse, "R3", "commit_pulse", commit_pulse, 1);
          chk(commit_epoch == mon_e, "R2", "commit_epoch", commit_epoch, mon_e);
          chk(commit_ip == (m_retried[mon_e] ? m_rip[mon_e] : m_ip[mon_e]), "R5", "commit_ip",
              commit_ip, m_retried[mon_e] ? m_rip[mon_e] : m_ip[mon_e]);
          chk(commit_rs == m_rs[mon_e], "R3", "commit_rs", commit_rs, m_rs[mon_e]);
          m_exp = m_exp + 8'd1;
          chk(next_epoch == m_exp, "R8", "next_epoch after commit", next_epoch, m_exp);
          n_commit++;
        end
      end else begin
        chk(!commit_pulse, "R2", "no commit without decision", commit_pulse, 0);
      end
    end
  end

  // retry back-pressure driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      retry_ready = rr_mode ? 1'($urandom % 2) : rr_force;
    end
  end

  task automatic ins(logic [7:0] e, logic [1:0] a);
    logic [15:0] ip, rip;
    logic [3:0]  rs;
    int guard;
    ip = 16'($urandom); rip = 16'($urandom); rs = 4'($urandom);
    m_ip[e] = ip; m_rip[e] = rip; m_rs[e] = rs; m_abi[e] = a;
    m_retried[e] = 0; m_pend[e] = 0;
    ins_ip = ip; ins_retry_ip = rip; ins_rs = rs; ins_epoch = e; ins_abi = a;
    ins_valid = 1'b1;
    guard = 0;
    while (!ins_ready && guard < 100) begin tick(); guard++; end
    tick();
    ins_valid = 1'b0;
  endtask

  task automatic fin(logic [7:0] e);
    done_epoch = e;
    done_pulse = 1'b1;
    tick();
    done_pulse = 1'b0;
  endtask

  task automatic drain(int target);
    int guard;
    bit found;
    guard = 0;
    while (n_commit < target && guard < 2000) begin
      found = 0;
      for (int k = 0; k < 256; k++) begin
        if (!found && m_pend[k]) begin
          m_pend[k] = 0;
          fin(8'(k));
          found = 1;
        end
      end
      if (!found) tick();
      guard++;
    end
    chk(n_commit >= target, "R5", "all entries retired", n_commit, target);
  endtask

  task automatic run_batch(int vprob, bit rev);
    logic [7:0] base;
    int ord[4];
    int j, t, target;
    base = m_exp;
    target = n_commit + 4;
    for (int k = 0; k < 4; k++) ord[k] = k;
    for (int k = 3; k > 0; k--) begin
      j = $urandom % (k + 1); t = ord[k]; ord[k] = ord[j]; ord[j] = t;
    end
    for (int k = 0; k < 4; k++) ins(base + 8'(ord[k]), 2'(ord[k]));
    chk(ins_ready == 1'b0, "R1", "ins_ready when full", ins_ready, 0);
    // attempted insert while full must be ignored
    ins_epoch = base + 8'd4; ins_abi = 2'd0; ins_valid = 1'b1;
    tick(); tick();
    ins_valid = 1'b0;
    chk(ins_ready == 1'b0, "R1", "ins_ready still low", ins_ready, 0);
    for (int k = 0; k < 4; k++) m_viol[k] = (($urandom % 100) < 32'(vprob));
    if (rev) begin
      for (int k = 3; k >= 1; k--) fin(base + 8'(k));
      tick(); tick(); tick();
      chk(next_epoch == base, "R2", "later epochs wait", next_epoch, base);
      chk(n_commit == target - 4, "R2", "no early commit", n_commit, target - 4);
      fin(base);
    end else begin
      for (int k = 3; k > 0; k--) begin
        j = $urandom % (k + 1); t = ord[k]; ord[k] = ord[j]; ord[j] = t;
      end
      for (int k = 0; k < 4; k++) begin
        fin(base + 8'(ord[k]));
        repeat ($urandom % 3) tick();
      end
    end
    drain(target);
    repeat (3) tick();
    chk(ins_ready == 1'b1, "R1", "ins_ready after drain", ins_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk(next_epoch == 8'd0, "R9", "next_epoch", next_epoch, 0);
    chk(ins_ready == 1'b1, "R9", "ins_ready", ins_ready, 1);
    chk(!commit_pulse && !retry_valid && !clr_pulse, "R9", "strobes low",
        {commit_pulse, retry_valid, clr_pulse}, 0);
    rst_n = 1'b1;
    tick();

    // R10: decision latency
    ins(8'd0, 2'd1);
    fin(8'd0);
    @(negedge clk);
    chk(commit_pulse == 1'b0, "R10", "no commit one edge after done", commit_pulse, 0);
    @(negedge clk);
    chk(commit_pulse == 1'b1, "R10", "commit two edges after done", commit_pulse, 1);
    @(negedge clk);
    chk(commit_pulse == 1'b0, "R3", "commit pulse one cycle", commit_pulse, 0);
    tick();

    // R6: retry held under back-pressure, second violation waits
    rr_mode = 0; rr_force = 0;
    tick();
    ins(8'd1, 2'd0);
    m_viol[0] = 1'b1;
    fin(8'd1);
    repeat (3) tick();
    chk(n_retry == 1, "R4", "first retry", n_retry, 1);
    chk(retry_valid == 1'b1, "R6", "retry held", retry_valid, 1);
    m_viol[0] = 1'b1;
    m_pend[1] = 0;
    fin(8'd1);
    repeat (4) tick();
    chk(n_retry == 1, "R6", "second retry blocked", n_retry, 1);
    chk(retry_epoch == 8'd1, "R6", "retry_epoch held", retry_epoch, 1);
    chk(next_epoch == 8'd1, "R6", "next_epoch held", next_epoch, 1);
    rr_force = 1;
    repeat (4) tick();
    chk(n_retry == 2, "R6", "second retry after accept", n_retry, 2);
    rr_mode = 1;
    drain(n_commit + 1);

    // R2: reverse completion order
    run_batch(0, 1);
    run_batch(50, 1);

    // random traffic across the epoch wrap (R8)
    for (int b = 0; b < 66; b++) run_batch(30, 0);
    chk(n_commit > 256, "R8", "commits past wrap", n_commit, 257);
    chk(next_epoch == m_exp, "R8", "next_epoch after wrap", next_epoch, m_exp);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule